// File: doc/BRIEF.md
# Serial Master with Strobe Handshake

This block is a synchronous serial engine that makes its own shift clock from the system clock. A programmable divider sets the clock rate. It sends and receives 8-bit units, least significant bit first. The shift clock rests high. Data leaves on the falling edge and the incoming line is sampled on the rising edge. Software sets the initialization enable and then asks for a transfer of one or more bytes. From then on the block paces itself against a busy line driven by the remote device.

Clocking of each byte begins only after the busy line has stayed at its go level for at least one and a half shift-clock periods. Once a byte has begun, all of its eight clocks are issued, even if the remote side withdraws permission partway through. When a byte is finished, the remote side is asked for permission again.

A strobe output marks the end of a transfer. It can pulse once after the whole block or after every byte, and its polarity can be chosen. One shift-clock period after the final strobe, the status flag drops and a one-cycle done pulse is given.

Top module: `strobe_serial_master`

## Requirements
- R1: After reset, and whenever initEn is low, sclk is 1, xferBusy is 0, done is 0 and strobe rests at its idle level. The idle level equals strbInv: 0 means the strobe is active-high and idles low, 1 means it is active-low and idles high.
- R2: With initEn high and xferBusy low, a startReq pulse sets xferBusy. A startReq that arrives while xferBusy is high is ignored.
- R3: The busy input is at its go level when busyIn equals busyInv. The first falling edge of a byte comes no sooner than 1.5 shift-clock periods (3*(clkDiv+1) system clocks) after busyIn reaches the go level. No shift clocks are issued while busyIn is at the stop level.
- R4: Each half period of sclk lasts clkDiv+1 system clocks. Each byte has exactly 8 falling and 8 rising sclk edges, and sclk returns high after the last rising edge.
- R5: sout carries txByte least significant bit first. Bit i is valid at the i-th rising sclk edge of the byte.
- R6: sin is sampled on the rising sclk edges, least significant bit first. After each byte, rxValid pulses for one cycle while rxByte holds the assembled byte.
- R7: If busyIn moves to the stop level during a byte, the byte still completes all 8 clocks. No further clocks follow until busyIn is qualified again.
- R8: One transfer moves byteCount+1 bytes.
- R9: The active strobe lasts one shift-clock period (2*(clkDiv+1) system clocks) and comes only while xferBusy is high.
- R10: With perByte at 1, the strobe pulses after every byte. With perByte at 0, it pulses once, after the last byte.
- R11: xferBusy falls 2*(clkDiv+1) system clocks after the final strobe ends. done is high for exactly that one cycle.
- R12: Lowering initEn during a transfer abandons it at the next clock edge. In that case no done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initEn | input | 1 | Initialization enable; low holds the block idle |
| startReq | input | 1 | Request to begin a transfer |
| byteCount | input | CNT_W | Bytes per transfer minus one |
| perByte | input | 1 | Strobe after each byte (1) or after the block (0) |
| strbInv | input | 1 | Strobe polarity: 1 gives an active-low strobe |
| busyInv | input | 1 | Go level of busyIn |
| clkDiv | input | DIV_W | Half period of sclk minus one, in system clocks |
| busyIn | input | 1 | Busy handshake from the remote device |
| sin | input | 1 | Serial data in |
| txByte | input | DATA_W | Byte to send, taken at the start of each byte |
| sclk | output | 1 | Shift clock |
| sout | output | 1 | Serial data out |
| strobe | output | 1 | End-of-transfer strobe |
| xferBusy | output | 1 | Transfer status flag |
| rxByte | output | DATA_W | Last received byte |
| rxValid | output | 1 | One-cycle pulse when rxByte is updated |
| done | output | 1 | One-cycle pulse when the transfer finishes |

## Verification
The assertions assume that strbInv stays steady while a strobe is active. They also assume that startReq is only a request and cannot disturb a transfer already in flight. The stimulus changes the polarity and divider inputs only while the block is idle, and it drives every input on the falling system-clock edge. The busy line moves only between bytes, or once partway through a byte to exercise the byte-boundary stop, so that the qualification window can be measured from a known edge.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_QUAL,
    PH_SHIFT,
    PH_STRB,
    PH_TAIL
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;   // divider and shifter active
    logic load;  // first falling edge of a byte
    logic fall;  // later falling edge
    logic rise;  // rising edge, sample input
    logic last;  // final rising edge of a byte
  } dp_ctl_t;
endpackage

// File: rtl/ssm_datapath.sv
module ssm_datapath
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sin,
  output logic              tick,
  output logic              sclk,
  output logic              sout,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);
  logic [DIV_W-1:0]  divCnt;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  assign tick   = ctl.run && (divCnt == clkDiv);
  assign rxNext = {sin, rxShift[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!ctl.run || (divCnt == clkDiv)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk    <= 1'b1;
      sout    <= 1'b1;
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (!ctl.run) begin
        sclk <= 1'b1;
        sout <= 1'b1;
      end else if (ctl.load) begin
        sclk    <= 1'b0;
        sout    <= txByte[0];
        txShift <= txByte >> 1;
      end else if (ctl.fall) begin
        sclk    <= 1'b0;
        sout    <= txShift[0];
        txShift <= txShift >> 1;
      end else if (ctl.rise) begin
        sclk    <= 1'b1;
        rxShift <= rxNext;
        if (ctl.last) begin
          rxByte  <= rxNext;
          rxValid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssm_control.sv
module ssm_control
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initEn,
  input  logic             startReq,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             perByte,
  input  logic             busyInv,
  input  logic             busyIn,
  input  logic             tick,
  output dp_ctl_t          ctl,
  output logic             strbActive,
  output logic             xferBusy,
  output logic             done
);
  localparam int HC_W = $clog2(2 * DATA_W);
  localparam logic [HC_W-1:0] HALF_LAST = HC_W'(2 * DATA_W - 2);

  phase_t           phase;
  logic [1:0]       busySync;
  logic             go;
  logic [1:0]       qualCnt;
  logic [HC_W-1:0]  halfCnt;
  logic [CNT_W-1:0] bytesLeft;
  logic             finalByte;
  logic             phCnt;

  assign go = (busySync[1] == busyInv);

  always_comb begin
    ctl.run  = initEn && (phase != PH_IDLE);
    ctl.load = ctl.run && tick && (phase == PH_QUAL) && go && (qualCnt == 2'd3);
    ctl.rise = ctl.run && tick && (phase == PH_SHIFT) && !halfCnt[0];
    ctl.fall = ctl.run && tick && (phase == PH_SHIFT) && halfCnt[0];
    ctl.last = ctl.rise && (halfCnt == HALF_LAST);
  end

  assign strbActive = initEn && (phase == PH_STRB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busySync <= '0;
    else       busySync <= {busySync[0], busyIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      xferBusy  <= 1'b0;
      done      <= 1'b0;
      qualCnt   <= '0;
      halfCnt   <= '0;
      bytesLeft <= '0;
      finalByte <= 1'b0;
      phCnt     <= 1'b0;
    end else if (!initEn) begin
      phase    <= PH_IDLE;
      xferBusy <= 1'b0;
      done     <= 1'b0;
      qualCnt  <= '0;
      halfCnt  <= '0;
      phCnt    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (startReq) begin
          phase     <= PH_QUAL;
          xferBusy  <= 1'b1;
          bytesLeft <= byteCount;
          qualCnt   <= '0;
        end
        PH_QUAL: if (tick) begin
          if (!go) begin
            qualCnt <= '0;
          end else if (qualCnt == 2'd3) begin
            qualCnt <= '0;
            halfCnt <= '0;
            phase   <= PH_SHIFT;
          end else begin
            qualCnt <= qualCnt + 2'd1;
          end
        end
        PH_SHIFT: if (tick) begin
          if (halfCnt == HALF_LAST) begin
            halfCnt <= '0;
            if (bytesLeft == '0) begin
              finalByte <= 1'b1;
              phase     <= PH_STRB;
            end else begin
              bytesLeft <= bytesLeft - CNT_W'(1);
              finalByte <= 1'b0;
              phase     <= perByte ? PH_STRB : PH_QUAL;
            end
          end else begin
            halfCnt <= halfCnt + HC_W'(1);
          end
        end
        PH_STRB: if (tick) begin
          phCnt <= ~phCnt;
          if (phCnt) phase <= finalByte ? PH_TAIL : PH_QUAL;
        end
        PH_TAIL: if (tick) begin
          phCnt <= ~phCnt;
          if (phCnt) begin
            phase    <= PH_IDLE;
            xferBusy <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strobe_serial_master.sv
module strobe_serial_master
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initEn,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              perByte,
  input  logic              strbInv,
  input  logic              busyInv,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              busyIn,
  input  logic              sin,
  input  logic [DATA_W-1:0] txByte,
  output logic              sclk,
  output logic              sout,
  output logic              strobe,
  output logic              xferBusy,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              done
);
  dp_ctl_t ctl;
  logic    tick;
  logic    strbActive;

  ssm_control #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .initEn(initEn), .startReq(startReq),
    .byteCount(byteCount), .perByte(perByte), .busyInv(busyInv),
    .busyIn(busyIn), .tick(tick), .ctl(ctl), .strbActive(strbActive),
    .xferBusy(xferBusy), .done(done)
  );

  ssm_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clkDiv(clkDiv), .txByte(txByte),
    .sin(sin), .tick(tick), .sclk(sclk), .sout(sout), .rxByte(rxByte),
    .rxValid(rxValid)
  );

  assign strobe = strbActive ^ strbInv;
endmodule

// File: rtl/strobe_serial_master_chk.sv
module strobe_serial_master_chk (
  input logic clk,
  input logic rstN,
  input logic initEn,
  input logic startReq,
  input logic strbInv,
  input logic sclk,
  input logic strobe,
  input logic xferBusy,
  input logic rxValid,
  input logic done
);
  // R1
  idle_sclk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferBusy |-> sclk);

  // R2
  start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && initEn && !xferBusy) |=> xferBusy);

  // R6
  rx_valid_in_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (xferBusy && sclk));

  // R9
  strobe_in_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != strbInv) |-> xferBusy);

  // R11
  done_on_flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!xferBusy && $past(xferBusy)));

  // R12
  init_low_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initEn |=> (!xferBusy && !done));
endmodule

bind strobe_serial_master strobe_serial_master_chk chk_i (
  .clk(clk), .rstN(rstN), .initEn(initEn), .startReq(startReq),
  .strbInv(strbInv), .sclk(sclk), .strobe(strobe), .xferBusy(xferBusy),
  .rxValid(rxValid), .done(done)
);

// File: tb/strobe_serial_master_test.sv
module strobe_serial_master_test;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [7:0] div;
    logic [3:0] cnt;
    logic       perByte;
    logic       sInv;
    logic       bInv;
    logic [7:0] tx;
    logic [7:0] rx;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 4'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    '{8'd3, 4'd2, 1'b1, 1'b1, 1'b0, 8'h81, 8'hF0},
    '{8'd0, 4'd1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h01},
    '{8'd5, 4'd1, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h96},
    '{8'd2, 4'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3}
  };

  logic clk = 1'b0, rstN = 1'b0, initEn = 1'b0, startReq = 1'b0;
  logic [3:0] byteCount = '0;
  logic perByte = 1'b0, strbInv = 1'b0, busyInv = 1'b0, busyIn = 1'b1, sin = 1'b0;
  logic [7:0] clkDiv = '0, txByte = '0;
  logic sclk, sout, strobe, xferBusy, rxValid, done;
  logic [7:0] rxByte;

  int total = 0, bad = 0, mTotal = 0, mBad = 0;
  int rises = 0, falls = 0, strbPulses = 0, doneCnt = 0, rxCnt = 0;
  int bitIdx = 0, strbWidth = 0, sinceStrb = 0;
  logic [7:0] curTx = '0, curRx = '0;
  int curDiv = 0;
  logic prevSclk = 1'b1, prevBusy = 1'b0, prevStrb = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  strobe_serial_master uut (
    .clk(clk), .rstN(rstN), .initEn(initEn), .startReq(startReq),
    .byteCount(byteCount), .perByte(perByte), .strbInv(strbInv),
    .busyInv(busyInv), .clkDiv(clkDiv), .busyIn(busyIn), .sin(sin),
    .txByte(txByte), .sclk(sclk), .sout(sout), .strobe(strobe),
    .xferBusy(xferBusy), .rxByte(rxByte), .rxValid(rxValid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // passive monitor, sampled on the falling system edge
  always @(negedge clk) begin
    if (rstN) begin
      logic act;
      act = (strobe != strbInv);
      if (xferBusy && !prevBusy) bitIdx = 0;
      if (!sclk && prevSclk) falls++;
      if (sclk && !prevSclk) begin
        mTotal++;
        if (sout != curTx[bitIdx]) begin
          mBad++;
          $display("FAIL R5 act=%0d exp=%0d", sout, curTx[bitIdx]);
        end
        rises++;
        bitIdx = (bitIdx + 1) % 8;
      end
      if (rxValid) begin
        rxCnt++;
        mTotal++;
        if (rxByte != curRx) begin
          mBad++;
          $display("FAIL R6 act=%0d exp=%0d", rxByte, curRx);
        end
      end
      if (act) strbWidth++;
      else sinceStrb++;
      if (!act && prevStrb) begin
        strbPulses++;
        mTotal++;
        if (strbWidth != 2 * (curDiv + 1)) begin
          mBad++;
          $display("FAIL R9 act=%0d exp=%0d", strbWidth, 2 * (curDiv + 1));
        end
        strbWidth = 0;
        sinceStrb = 0;
      end
      if (done) begin
        doneCnt++;
        mTotal += 2;
        if (xferBusy || !prevBusy) begin
          mBad++;
          $display("FAIL R11 act=%0d exp=%0d", xferBusy, 0);
        end
        if (sinceStrb != 2 * (curDiv + 1)) begin
          mBad++;
          $display("FAIL R11 act=%0d exp=%0d", sinceStrb, 2 * (curDiv + 1));
        end
      end
      sin = curRx[bitIdx];
      prevSclk = sclk;
      prevBusy = xferBusy;
      prevStrb = act;
    end
  end

  task automatic setGo(input bit g);
    busyIn = g ? busyInv : ~busyInv;
  endtask

  task automatic setup(input vec_t v);
    @(negedge clk);
    clkDiv = v.div; curDiv = int'(v.div);
    byteCount = v.cnt; perByte = v.perByte; strbInv = v.sInv;
    busyInv = v.bInv; txByte = v.tx; curTx = v.tx; curRx = v.rx;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int n;
    n = 0;
    while (xferBusy && n < 20000) begin @(negedge clk); n++; end
    chk(!xferBusy, req, int'(xferBusy), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total + mTotal, bad + mBad);
    $finish;
  end

  initial begin
    int r0, f0, s0, d0, x0, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sclk === 1'b1, "R1", int'(sclk), 1);
    chk(xferBusy === 1'b0 && done === 1'b0, "R1", int'(xferBusy), 0);
    chk(strobe === strbInv, "R1", int'(strobe), int'(strbInv));
    rstN = 1'b1;
    @(negedge clk); initEn = 1'b1;

    // vector walk: R4 R5 R6 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i]);
      setGo(1'b1);
      repeat (4) @(negedge clk);
      chk(strobe === strbInv, "R1", int'(strobe), int'(strbInv));
      r0 = rises; f0 = falls; s0 = strbPulses; d0 = doneCnt; x0 = rxCnt;
      pulseStart();
      chk(xferBusy === 1'b1, "R2", int'(xferBusy), 1);
      waitIdle("R11");
      repeat (2) @(negedge clk);
      chk(rises - r0 == 8 * (VECS[i].cnt + 1), "R8", rises - r0, 8 * (VECS[i].cnt + 1));
      chk(falls - f0 == 8 * (VECS[i].cnt + 1), "R4", falls - f0, 8 * (VECS[i].cnt + 1));
      chk(rxCnt - x0 == VECS[i].cnt + 1, "R6", rxCnt - x0, VECS[i].cnt + 1);
      chk(strbPulses - s0 == (VECS[i].perByte ? VECS[i].cnt + 1 : 1), "R10",
          strbPulses - s0, VECS[i].perByte ? VECS[i].cnt + 1 : 1);
      chk(doneCnt - d0 == 1, "R11", doneCnt - d0, 1);
      chk(sclk === 1'b1, "R4", int'(sclk), 1);
    end

    // R3 qualification window, R2 start ignored while busy
    setup('{8'd3, 4'd0, 1'b0, 1'b0, 1'b0, 8'h6E, 8'h2B});
    setGo(1'b0);
    repeat (4) @(negedge clk);
    r0 = rises; f0 = falls;
    pulseStart();
    repeat (60) @(negedge clk);
    chk(falls == f0 && sclk === 1'b1, "R3", falls - f0, 0);
    chk(xferBusy === 1'b1, "R2", int'(xferBusy), 1);
    setGo(1'b1);
    n = 0;
    while (sclk && n < 1000) begin @(negedge clk); n++; end
    chk(n >= 3 * 4 + 1 && n <= 4 * 4 + 4, "R3", n, 3 * 4 + 2);
    pulseStart();
    waitIdle("R2");
    chk(rises - r0 == 8, "R2", rises - r0, 8);

    // R7 stop at byte boundary
    setup('{8'd1, 4'd1, 1'b0, 1'b0, 1'b1, 8'hC9, 8'h7D});
    setGo(1'b1);
    repeat (4) @(negedge clk);
    r0 = rises;
    pulseStart();
    n = 0;
    while (rises - r0 < 2 && n < 1000) begin @(negedge clk); n++; end
    setGo(1'b0);
    repeat (100) @(negedge clk);
    chk(rises - r0 == 8, "R7", rises - r0, 8);
    chk(sclk === 1'b1 && xferBusy === 1'b1, "R7", int'(sclk), 1);
    setGo(1'b1);
    waitIdle("R7");
    chk(rises - r0 == 16, "R7", rises - r0, 16);

    // R12 abort
    setup('{8'd2, 4'd2, 1'b1, 1'b1, 1'b0, 8'h33, 8'h55});
    setGo(1'b1);
    repeat (4) @(negedge clk);
    r0 = rises; d0 = doneCnt;
    pulseStart();
    n = 0;
    while (rises - r0 < 3 && n < 1000) begin @(negedge clk); n++; end
    initEn = 1'b0;
    @(negedge clk);
    chk(xferBusy === 1'b0, "R12", int'(xferBusy), 0);
    chk(sclk === 1'b1, "R12", int'(sclk), 1);
    chk(strobe === strbInv, "R1", int'(strobe), int'(strbInv));
    repeat (40) @(negedge clk);
    chk(doneCnt == d0 && rises - r0 == 3, "R12", rises - r0, 3);
    pulseStart();
    @(negedge clk);
    chk(xferBusy === 1'b0, "R1", int'(xferBusy), 0);

    $display("  test done: total=%0d bad=%0d", total + mTotal, bad + mBad);
    $finish;
  end
endmodule